// File: doc/BRIEF.md
# Phase-Difference Frequency Discriminator

This block turns a stream of phase words, each qualified by a valid strobe, into frequency estimates. Each accepted phase word is first scaled by 1, 2, 4 or 8, modulo one full turn. This strips low-order phase modulation before any frequency is measured. The block then subtracts the scaled phase seen a programmable number of samples earlier, which forms a comb differentiator H(z) = 1 - z^-(k+1). Finally it keeps only every Nth difference and presents it on a registered output with its own valid strobe.

The control inputs are a run enable and three small codes. One code picks the multiplier, one the lag and one the decimation factor. The codes are latched only while the run enable is low. Raising the enable starts a fresh measurement: the history is empty and the decimation count is zero. Phase words are two's-complement fractions of a turn. Differences wrap at the word width, so a step across the half-turn boundary reads as the correct small frequency.

Top module: `freq_disc`

## Requirements
- R1: The multiplier code selects a left shift of the accepted phase word: 00 by 0 bits, 01 by 1 bit, 10 by 2 bits, 11 by 3 bits. Bits shifted past the top are dropped and zeros fill the bottom.
- R2: Each difference equals the current scaled phase minus the scaled phase accepted lag+1 samples earlier, where lag is the 3-bit lag code (0..7 gives 1..8 samples).
- R3: The difference is taken modulo 2^PH_W in two's complement, so a step across the half-turn boundary gives the small wrapped value.
- R4: After the enable rises, no difference is produced until lag+1 phase words have been accepted. The sample with zero-based index lag+1 yields the first difference.
- R5: The decimation code gives factor N equal to its value for 001..111, and N = 8 for 000. Only the N-th, 2N-th, 3N-th ... differences after the enable rises are output.
- R6: While the enable is low, fq_vld stays 0 and the history and the decimation count are cleared.
- R7: Code changes made while the enable is high have no effect. The codes in force are the ones present in the last cycle the enable was low.
- R8: fq_vld is high for exactly one cycle, the cycle after the clock edge that accepted the producing phase word. Cycles without ph_vld advance nothing.
- R9: During and directly after reset, fq_vld and fq_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; codes load while low |
| mult_code | input | 2 | Phase multiplier code |
| lag_code | input | 3 | Differentiator lag minus one |
| dec_code | input | 3 | Decimation factor (000 = 8) |
| ph_in | input | PH_W | Phase word, fraction of a turn |
| ph_vld | input | 1 | Phase word valid |
| fq_out | output | PH_W | Frequency word |
| fq_vld | output | 1 | Frequency word valid |

## Verification
The bench sweeps all 256 combinations of multiplier, lag and decimation codes with 8-bit phase words. Each combination gets a quadratic phase ramp that crosses the half-turn boundary often, so wrong shift amounts, wrong lag taps and missing wraparound each give different wrong values. Idle gaps between samples separate advancing on a valid strobe from advancing on every clock. Deliberately wrong codes applied while running show whether latched settings are held. Fill and decimation counts are checked cycle by cycle, so an off-by-one in the first output or in the spacing between outputs shows up as a strobe in the wrong cycle.

// File: rtl/fd_pkg.sv
package fd_pkg;
  localparam int MULT_W = 2;
  localparam int LAG_W  = 3;
  localparam int DEC_W  = 3;
  localparam int DEPTH  = 1 << LAG_W;
  localparam int FILL_W = LAG_W + 1;

  typedef struct packed {
    logic [MULT_W-1:0] mult;
    logic [LAG_W-1:0]  lag;
    logic [DEC_W-1:0]  dec;
  } fd_cfg_t;
endpackage

// File: rtl/fd_scaler.sv
module fd_scaler #(
  parameter int W = 12,
  parameter int SW = 2
) (
  input  logic [SW-1:0] shift,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout
);
  always_comb begin
    dout = din << shift;
  end
endmodule

// File: rtl/fd_lag_line.sv
module fd_lag_line #(
  parameter int W = 12,
  parameter int LAG_W = 3,
  localparam int DEPTH = 1 << LAG_W,
  localparam int FILL_W = LAG_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              push,
  input  logic [W-1:0]      din,
  input  logic [LAG_W-1:0]  sel,
  output logic [W-1:0]      tap,
  output logic              primed,
  output logic [FILL_W-1:0] fill
);
  logic [W-1:0] stage [DEPTH];

  always_ff @(posedge clk) begin
    if (push) stage[0] <= din;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (push) stage[i] <= stage[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) fill <= '0;
    else if (push && fill != FILL_W'(DEPTH)) fill <= fill + 1'b1;
  end

  assign tap    = stage[sel];
  assign primed = fill > {1'b0, sel};
endmodule

// File: rtl/fd_decimator.sv
module fd_decimator #(
  parameter int DEC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  input  logic [DEC_W-1:0] code,
  output logic             fire,
  output logic [DEC_W-1:0] cnt
);
  logic [DEC_W-1:0] last;

  always_comb begin
    last = code - 1'b1;
  end

  assign fire = step && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (fire)   cnt <= '0;
    else if (step)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/freq_disc.sv
module freq_disc
  import fd_pkg::*;
#(
  parameter int PH_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [MULT_W-1:0] mult_code,
  input  logic [LAG_W-1:0]  lag_code,
  input  logic [DEC_W-1:0]  dec_code,
  input  logic [PH_W-1:0]   ph_in,
  input  logic              ph_vld,
  output logic [PH_W-1:0]   fq_out,
  output logic              fq_vld
);
  fd_cfg_t cfg_q;
  logic [PH_W-1:0] scaled, tap, diff;
  logic accept, primed, dvld, fire;
  logic [FILL_W-1:0] fill;
  logic [DEC_W-1:0] dcnt;

  always_ff @(posedge clk) begin
    if (rst)     cfg_q <= '0;
    else if (!en) cfg_q <= '{mult: mult_code, lag: lag_code, dec: dec_code};
  end

  assign accept = en && ph_vld;

  fd_scaler #(.W(PH_W), .SW(MULT_W)) u_scale (
    .shift(cfg_q.mult), .din(ph_in), .dout(scaled)
  );

  fd_lag_line #(.W(PH_W), .LAG_W(LAG_W)) u_line (
    .clk(clk), .rst(rst), .clr(!en), .push(accept), .din(scaled),
    .sel(cfg_q.lag), .tap(tap), .primed(primed), .fill(fill)
  );

  assign diff = scaled - tap;
  assign dvld = accept && primed;

  fd_decimator #(.DEC_W(DEC_W)) u_dec (
    .clk(clk), .rst(rst), .clr(!en), .step(dvld), .code(cfg_q.dec),
    .fire(fire), .cnt(dcnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fq_vld <= 1'b0;
      fq_out <= '0;
    end else begin
      fq_vld <= fire;
      if (fire) fq_out <= diff;
    end
  end
endmodule

// File: rtl/freq_disc_chk.sv
module freq_disc_chk
  import fd_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              ph_vld,
  input logic              fq_vld,
  input fd_cfg_t           cfg_q,
  input logic [FILL_W-1:0] fill,
  input logic [DEC_W-1:0]  dcnt
);
  p_vld_needs_en_r6: assert property (@(posedge clk) disable iff (rst)
    fq_vld |-> $past(en));
  p_off_silent_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> !fq_vld);
  p_vld_from_sample_r8: assert property (@(posedge clk) disable iff (rst)
    fq_vld |-> $past(ph_vld));
  p_cfg_held_r7: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en)) |-> $stable(cfg_q));
  p_primed_r4: assert property (@(posedge clk) disable iff (rst)
    fq_vld |-> (fill > {1'b0, cfg_q.lag}));
  p_dec_restart_r5: assert property (@(posedge clk) disable iff (rst)
    fq_vld |-> (dcnt == '0));
endmodule

bind freq_disc freq_disc_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .ph_vld(ph_vld), .fq_vld(fq_vld),
  .cfg_q(cfg_q), .fill(fill), .dcnt(dcnt)
);

// File: tb/tb_freq_disc.sv
module tb_freq_disc;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [1:0] mult_code = '0;
  logic [2:0] lag_code = '0;
  logic [2:0] dec_code = '0;
  logic [W-1:0] ph_in = '0;
  logic ph_vld = 1'b0;
  logic [W-1:0] fq_out;
  logic fq_vld;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  freq_disc #(.PH_W(W)) dut (
    .clk(clk), .rst(rst), .en(en), .mult_code(mult_code), .lag_code(lag_code),
    .dec_code(dec_code), .ph_in(ph_in), .ph_vld(ph_vld),
    .fq_out(fq_out), .fq_vld(fq_vld)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, then check at the next falling edge.
  task automatic cyc(input logic v, input logic [W-1:0] p,
                     input logic ev, input logic [W-1:0] eval, input string tag);
    ph_vld = v;
    ph_in  = p;
    @(negedge clk);
    chk({tag, " vld"}, {7'd0, fq_vld}, {7'd0, ev});
    if (ev) chk({tag, " val"}, fq_out, eval);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk("R9 reset vld", {7'd0, fq_vld}, 8'd0);
    chk("R9 reset out", fq_out, 8'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 after reset vld", {7'd0, fq_vld}, 8'd0);
    chk("R9 after reset out", fq_out, 8'd0);

    for (int cfg = 0; cfg < 256; cfg++) begin
      logic [W-1:0] sc [32];
      int m, l, d, n, nd;
      m = cfg & 3;
      l = (cfg >> 2) & 7;
      d = (cfg >> 5) & 7;
      n = (d == 0) ? 8 : d;
      // load codes while disabled (R6 clear, R7 latch point)
      en = 1'b0;
      mult_code = 2'(m); lag_code = 3'(l); dec_code = 3'(d);
      cyc(1'b1, 8'h5a, 1'b0, '0, "R6 disabled");
      // run with scrambled codes on the pins: they must be ignored (R7)
      en = 1'b1;
      mult_code = ~2'(m); lag_code = 3'(l + 3); dec_code = 3'(d + 5);
      nd = 0;
      for (int k = 0; k < 24; k++) begin
        logic [W-1:0] p;
        logic ev;
        logic [W-1:0] ex;
        if (k % 5 == 3) cyc(1'b0, 8'(k * 91), 1'b0, '0, "R8 idle gap");
        p = 8'(k * 37 + k * k * 13 + cfg * 11);
        sc[k] = 8'(p << m);                 // R1
        ev = 1'b0;
        ex = '0;
        if (k >= l + 1) begin               // R4
          nd++;
          if (nd % n == 0) begin            // R5
            ev = 1'b1;
            ex = 8'(sc[k] - sc[k - l - 1]); // R2 R3 wrapped difference
          end
        end
        cyc(1'b1, p, ev, ex, "R1 R2 R3 R4 R5 R7");
      end
      en = 1'b0;
      cyc(1'b1, 8'h33, 1'b0, '0, "R6 off");
      cyc(1'b1, 8'h77, 1'b0, '0, "R6 off");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule